// File: doc/BRIEF.md
# Two-Wire Register-Pointer Slave

This block is a serial slave on a two-wire bus. It answers one fixed 7-bit device address and gives access to a 256-byte register space. SCL and SDA are brought into the system clock domain through a short flip-flop chain. The block finds START, repeated START and STOP conditions and moves bytes most significant bit first. It acknowledges on an open-drain SDA by asserting an output-enable that pulls the line low.

In a write, the first byte after the address loads a byte-wide word pointer. Each later byte is stored at the pointer, and the pointer then moves up by one. In a read, bytes come out starting at the pointer, which also moves up after each byte. The pointer survives both STOP and repeated START. A master can therefore set the pointer and read back from it in one transaction without freeing the bus.

Internal logic reaches the same storage through a plain synchronous port. A write takes effect at the clock edge, and read data appears one cycle after the address.

Top module: `i2c_regptr_slave`

## Requirements
- R1: Only the address byte 0xD0 (write) or 0xD1 (read) is acknowledged. These are the 7-bit address 0x68 followed by the direction bit, 0 for write and 1 for read. For any other address the slave releases SDA, stores nothing and leaves the pointer unchanged until the next START or STOP.
- R2: Every byte, in either direction, moves most significant bit first. Bit 7 is the first bit on the wire.
- R3: In a write transfer, the first byte after the address byte loads the word pointer and is not stored.
- R4: Each later byte of a write transfer is stored at the pointer, and the pointer then advances by one.
- R5: The slave holds SDA low through the high phase of the ninth clock after a matching address byte and after every received write byte. It releases SDA after that clock's falling edge.
- R6: After a matching read address, the slave sends the byte at the pointer and advances the pointer after each byte. It fetches the next byte only when the master acknowledges.
- R7: When the master answers a byte with NACK (SDA high on the ninth clock), the slave releases SDA and drives nothing until a START or STOP.
- R8: A repeated START begins a new address phase and keeps the pointer. A sequence of START, 0xD0, word address, repeated START, 0xD1 and reads returns data from the word address just written.
- R9: The pointer wraps from 0xFF to 0x00.
- R10: The pointer is 0x00 after reset and keeps its value across STOP. A read with no pointer write continues where the last transfer stopped.
- R11: Internal port: host_we stores host_wdata at host_addr on the clock edge. host_rdata shows the byte at host_addr one cycle later. If a bus write and a host write hit the same cycle, the bus write wins.
- R12: sda_oe changes only while SCL is low, so the slave never creates a false START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock as seen on the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| host_addr | input | 8 | Internal port address |
| host_we | input | 1 | Internal port write strobe |
| host_wdata | input | 8 | Internal port write data |
| host_rdata | output | 8 | Internal port read data, one cycle latency |

## Verification
The hardest case to reach is the pointer's path across boundaries that only a master can create. This covers a repeated START between the pointer write and the read, a NACK in the middle of a read followed by idle clocks, and a pointer that wraps past 0xFF. The bench contains a bit-level bus master whose tasks produce START, repeated START, STOP, byte writes and byte reads with chosen ACK values. Each scenario places storage contents through the internal port beforehand, so that every byte read back shows exactly where the pointer stood. Monitors watch sda_oe against SCL and during the period after a NACK.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK,
    ST_RX,
    ST_TX,
    ST_MACK,
    ST_IGNORE
  } bus_state_t;

  // true when the upper seven bits of an address byte name this device
  function automatic logic addr_hit(input logic [7:0] addr_byte, input logic [6:0] dev);
    return addr_byte[7:1] == dev;
  endfunction

endpackage

// File: rtl/i2cs_line_sync.sv
module i2cs_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_q    <= scl_pipe[STAGES-1];
      sda_q    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_evt = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_evt  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/i2cs_regfile.sv
module i2cs_regfile #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_we,
  input  logic [7:0]    bus_wdata,
  output logic [7:0]    bus_rdata,
  input  logic [AW-1:0] host_addr,
  input  logic          host_we,
  input  logic [7:0]    host_wdata,
  output logic [7:0]    host_rdata
);
  localparam int DEPTH = 1 << AW;

  logic [7:0] mem [DEPTH];

  // bus side wins a same-cycle collision (R11)
  always_ff @(posedge clk) begin
    if (bus_we)
      mem[bus_addr] <= bus_wdata;
    else if (host_we)
      mem[host_addr] <= host_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) host_rdata <= '0;
    else        host_rdata <= mem[host_addr];
  end

  assign bus_rdata = mem[bus_addr];

endmodule

// File: rtl/i2cs_protocol.sv
module i2cs_protocol
  import i2cs_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h68,
  parameter int         PTR_W    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_s,
  input  logic             sda_s,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_evt,
  input  logic             stop_evt,
  input  logic [7:0]       mem_rdata,
  output logic [PTR_W-1:0] mem_addr,
  output logic             mem_we,
  output logic [7:0]       mem_wdata,
  output logic             sda_drive_low
);
  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return p + 1'b1;
  endfunction

  bus_state_t       state;
  logic [2:0]       bit_cnt;
  logic [1:0]       phase;
  logic [7:0]       rx_sh, tx_sh;
  logic             rw, first_byte;
  logic [PTR_W-1:0] ptr;

  // named internal events
  logic [7:0] rx_byte;
  logic       addr_done, rx_done, ptr_load, wr_fire, tx_fetch;

  assign rx_byte   = {rx_sh[6:0], sda_s};
  assign addr_done = (state == ST_ADDR) && scl_rise && (bit_cnt == 3'd7);
  assign rx_done   = (state == ST_RX) && scl_rise && (bit_cnt == 3'd7);
  assign ptr_load  = rx_done && first_byte;
  assign wr_fire   = rx_done && !first_byte;
  assign tx_fetch  = scl_rise && (phase == 2'd1) &&
                     (((state == ST_ACK) && rw) || ((state == ST_MACK) && !sda_s));

  assign mem_addr  = ptr;
  assign mem_we    = wr_fire;
  assign mem_wdata = rx_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  ptr <= '0;
    else if (ptr_load)           ptr <= rx_byte[PTR_W-1:0];
    else if (wr_fire || tx_fetch) ptr <= ptr_next(ptr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state         <= ST_IDLE;
      bit_cnt       <= '0;
      phase         <= '0;
      rx_sh         <= '0;
      tx_sh         <= '0;
      rw            <= 1'b0;
      first_byte    <= 1'b0;
      sda_drive_low <= 1'b0;
    end else if (start_evt) begin
      state         <= ST_ADDR;
      bit_cnt       <= '0;
      sda_drive_low <= 1'b0;
    end else if (stop_evt) begin
      state         <= ST_IDLE;
      sda_drive_low <= 1'b0;
    end else begin
      case (state)
        ST_ADDR: if (scl_rise) begin
          rx_sh   <= rx_byte;
          bit_cnt <= bit_cnt + 3'd1;
          if (bit_cnt == 3'd7) begin
            if (addr_hit(rx_byte, DEV_ADDR)) begin
              state      <= ST_ACK;
              phase      <= 2'd0;
              rw         <= rx_byte[0];
              first_byte <= 1'b1;
            end else begin
              state <= ST_IGNORE;
            end
          end
        end
        ST_ACK: begin
          if (scl_fall && phase == 2'd0) begin
            sda_drive_low <= 1'b1;
            phase         <= 2'd1;
          end else if (scl_rise && phase == 2'd1) begin
            phase <= 2'd2;
            if (rw) tx_sh <= mem_rdata;
          end else if (scl_fall && phase == 2'd2) begin
            bit_cnt <= '0;
            if (rw) begin
              state         <= ST_TX;
              sda_drive_low <= ~tx_sh[7];
            end else begin
              state         <= ST_RX;
              sda_drive_low <= 1'b0;
            end
          end
        end
        ST_RX: if (scl_rise) begin
          rx_sh   <= rx_byte;
          bit_cnt <= bit_cnt + 3'd1;
          if (ptr_load) first_byte <= 1'b0;
          if (bit_cnt == 3'd7) begin
            state <= ST_ACK;
            phase <= 2'd0;
          end
        end
        ST_TX: begin
          if (scl_rise) begin
            bit_cnt <= bit_cnt + 3'd1;
            if (bit_cnt == 3'd7) begin
              state <= ST_MACK;
              phase <= 2'd0;
            end
          end else if (scl_fall) begin
            tx_sh         <= {tx_sh[6:0], 1'b0};
            sda_drive_low <= ~tx_sh[6];
          end
        end
        ST_MACK: begin
          if (scl_fall && phase == 2'd0) begin
            sda_drive_low <= 1'b0;
            phase         <= 2'd1;
          end else if (scl_rise && phase == 2'd1) begin
            if (!sda_s) begin
              tx_sh <= mem_rdata;
              phase <= 2'd2;
            end else begin
              state <= ST_IGNORE;
            end
          end else if (scl_fall && phase == 2'd2) begin
            state         <= ST_TX;
            bit_cnt       <= '0;
            sda_drive_low <= ~tx_sh[7];
          end
        end
        default: ;
      endcase
    end
  end

  // ---------------- assertions ----------------
  assert_foreign_addr_silent_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_done && !addr_hit(rx_byte, DEV_ADDR) && !start_evt && !stop_evt)
      |=> (state == ST_IGNORE) && !sda_drive_low);

  assert_ptr_advance_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> ptr == ptr_next($past(ptr)));

  assert_ack_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ACK && phase != 2'd0) |-> sda_drive_low);

  assert_ignore_released_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IGNORE) |-> !sda_drive_low);

  assert_rstart_keeps_ptr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (state == ST_ADDR) && !sda_drive_low && $stable(ptr));

  assert_oe_moves_scl_low_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_drive_low) |-> !$past(scl_s));

endmodule

// File: rtl/i2c_regptr_slave.sv
module i2c_regptr_slave #(
  parameter logic [6:0] DEV_ADDR    = 7'h68,
  parameter int         PTR_W       = 8,
  parameter int         SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe,
  input  logic [PTR_W-1:0] host_addr,
  input  logic             host_we,
  input  logic [7:0]       host_wdata,
  output logic [7:0]       host_rdata
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  logic [PTR_W-1:0] bus_addr;
  logic             bus_we;
  logic [7:0]       bus_wdata, bus_rdata;

  i2cs_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  i2cs_protocol #(.DEV_ADDR(DEV_ADDR), .PTR_W(PTR_W)) u_proto (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt),
    .mem_rdata(bus_rdata), .mem_addr(bus_addr), .mem_we(bus_we),
    .mem_wdata(bus_wdata), .sda_drive_low(sda_oe)
  );

  i2cs_regfile #(.AW(PTR_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .host_addr(host_addr), .host_we(host_we), .host_wdata(host_wdata), .host_rdata(host_rdata)
  );

endmodule

// File: tb/i2c_regptr_slave_bench.sv
`timescale 1ns/1ps
module i2c_regptr_slave_bench;
  localparam int Q = 8;  // system clocks per quarter SCL period

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1, sda_m = 1'b1;
  logic       sda_line, sda_oe;
  logic [7:0] host_addr = '0, host_wdata = '0, host_rdata;
  logic       host_we = 1'b0;

  int n_checks = 0, n_fail = 0;
  bit done = 0;
  bit nack_watch = 0;
  int nack_viol = 0, scl_viol = 0;
  logic prev_oe = 1'b0;

  always #5 clk = ~clk;

  assign sda_line = sda_m & ~sda_oe;

  i2c_regptr_slave u_i2c_regptr_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .host_addr(host_addr), .host_we(host_we), .host_wdata(host_wdata), .host_rdata(host_rdata)
  );

  // monitors for R7 and R12
  always @(negedge clk) begin
    if (rst_n && sda_oe != prev_oe && scl_m) scl_viol++;
    if (nack_watch && sda_oe) nack_viol++;
    prev_oe = sda_oe;
  end

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic bus_start();
    sda_m = 1; scl_m = 1; tick(Q);
    sda_m = 0; tick(Q);
    scl_m = 0; tick(Q);
  endtask

  task automatic bus_rstart();
    sda_m = 1; tick(Q);
    scl_m = 1; tick(Q);
    sda_m = 0; tick(Q);
    scl_m = 0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 0; tick(Q);
    scl_m = 1; tick(Q);
    sda_m = 1; tick(Q);
  endtask

  // returns the level seen in the ninth clock (0 = ACK)
  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(Q);
      scl_m = 1; tick(2*Q);
      scl_m = 0; tick(Q);
    end
    sda_m = 1; tick(Q);
    scl_m = 1; tick(Q);
    ack = sda_line; tick(Q);
    scl_m = 0; tick(Q);
  endtask

  task automatic recv_byte(input logic master_nack, output logic [7:0] b);
    sda_m = 1;
    for (int i = 7; i >= 0; i--) begin
      tick(Q);
      scl_m = 1; tick(Q);
      b[i] = sda_line; tick(Q);
      scl_m = 0;
    end
    tick(Q);
    sda_m = master_nack; tick(Q);
    scl_m = 1; tick(2*Q);
    scl_m = 0; tick(Q);
    sda_m = 1;
  endtask

  task automatic host_wr(input logic [7:0] a, input logic [7:0] d);
    @(posedge clk); #2;
    host_addr = a; host_wdata = d; host_we = 1;
    @(posedge clk); #2;
    host_we = 0;
  endtask

  task automatic host_rd(input logic [7:0] a, output logic [7:0] d);
    @(posedge clk); #2;
    host_addr = a;
    @(posedge clk); #2;
    d = host_rdata;
  endtask

  task automatic t_reset();
    logic ack; logic [7:0] d;
    check("R12 sda_oe released after reset", sda_oe, 0);
    host_wr(8'h00, 8'hA5);
    bus_start();
    send_byte(8'hD1, ack);
    check("R1 read address 0xD1 acknowledged", ack, 0);
    recv_byte(1'b1, d);
    bus_stop();
    check("R10 pointer starts at 0x00", d, 8'hA5);
  endtask

  task automatic t_write_burst();
    logic ack; logic [7:0] d;
    bus_start();
    send_byte(8'hD0, ack);  check("R5 ACK after write address", ack, 0);
    check("R5 SDA released after ninth clock", sda_oe, 0);
    send_byte(8'h10, ack);  check("R5 ACK after word address", ack, 0);
    send_byte(8'h11, ack);  check("R5 ACK after data 0", ack, 0);
    send_byte(8'h22, ack);  check("R5 ACK after data 1", ack, 0);
    send_byte(8'h93, ack);  check("R5 ACK after data 2", ack, 0);
    bus_stop();
    host_rd(8'h10, d); check("R4 byte at 0x10", d, 8'h11);
    host_rd(8'h11, d); check("R4 byte at 0x11", d, 8'h22);
    host_rd(8'h12, d); check("R2 MSB-first byte at 0x12", d, 8'h93);
  endtask

  task automatic t_combined_read();
    logic ack; logic [7:0] d;
    bus_start();
    send_byte(8'hD0, ack);
    send_byte(8'h10, ack);
    bus_rstart();
    send_byte(8'hD1, ack); check("R8 ACK after repeated START", ack, 0);
    recv_byte(1'b0, d); check("R8 first byte from new pointer", d, 8'h11);
    recv_byte(1'b0, d); check("R6 second read byte", d, 8'h22);
    recv_byte(1'b1, d); check("R2 MSB-first read byte", d, 8'h93);
    nack_watch = 1;
    for (int i = 0; i < 9; i++) begin
      tick(Q); scl_m = 1; tick(2*Q); scl_m = 0; tick(Q);
    end
    nack_watch = 0;
    bus_stop();
  endtask

  task automatic t_continue_after_stop();
    logic ack; logic [7:0] d;
    host_wr(8'h13, 8'h5C);
    host_wr(8'h14, 8'hC3);
    bus_start();
    send_byte(8'hD1, ack);
    recv_byte(1'b0, d); check("R10 read resumes after STOP", d, 8'h5C);
    recv_byte(1'b1, d); check("R11 host-written byte on bus", d, 8'hC3);
    bus_stop();
  endtask

  task automatic t_wrap();
    logic ack; logic [7:0] d;
    bus_start();
    send_byte(8'hD0, ack);
    send_byte(8'hFE, ack);
    send_byte(8'h01, ack);
    send_byte(8'h02, ack);
    send_byte(8'h03, ack); check("R9 ACK on wrapped write", ack, 0);
    bus_stop();
    host_rd(8'hFE, d); check("R9 byte at 0xFE", d, 8'h01);
    host_rd(8'hFF, d); check("R9 byte at 0xFF", d, 8'h02);
    host_rd(8'h00, d); check("R9 wrapped byte at 0x00", d, 8'h03);
  endtask

  task automatic t_foreign_addr();
    logic ack; logic [7:0] d;
    host_wr(8'h20, 8'h00);
    host_wr(8'h01, 8'h3C);
    bus_start();
    send_byte(8'hA0, ack); check("R1 foreign address not acknowledged", ack, 1);
    send_byte(8'h20, ack); check("R1 no ACK while ignoring", ack, 1);
    send_byte(8'h77, ack); check("R1 no ACK on foreign data", ack, 1);
    bus_stop();
    host_rd(8'h20, d); check("R1 foreign write not stored", d, 8'h00);
    bus_start();
    send_byte(8'hD1, ack);
    recv_byte(1'b1, d); check("R1 pointer untouched by foreign transfer", d, 8'h3C);
    bus_stop();
  endtask

  task automatic t_pointer_only();
    logic ack; logic [7:0] d;
    host_wr(8'h31, 8'hEE);
    bus_start();
    send_byte(8'hD0, ack);
    send_byte(8'h30, ack);
    bus_stop();
    host_wr(8'h30, 8'h6A);
    host_rd(8'h31, d); check("R3 word address byte not stored", d, 8'hEE);
    bus_start();
    send_byte(8'hD1, ack);
    recv_byte(1'b1, d); check("R3 pointer loaded by first write byte", d, 8'h6A);
    bus_stop();
  endtask

  initial begin
    tick(5);
    rst_n = 1;
    tick(5);
    t_reset();
    t_write_burst();
    t_combined_read();
    t_continue_after_stop();
    t_wrap();
    t_foreign_addr();
    t_pointer_only();
    check("R7 SDA quiet after master NACK", nack_viol, 0);
    check("R12 sda_oe changed only with SCL low", scl_viol, 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

endmodule